// File: doc/BRIEF.md
# Feed-Protected Clock Synthesizer Control Registers

This block holds the programming state of an external frequency synthesizer: a multiplier, a pre-divider, an enable and a connect bit. Software writes the configuration and control words into holding registers. Those writes have no effect on the synthesizer until a two-word unlock pair is written to a dedicated feed address, and the feed writes must come one after the other. Only then do the pending values move into the active registers that drive the synthesizer. A stray value or an interleaved write cancels the unlock, so a runaway store cannot retune the clock.

A lock counter stands in for the analog lock detector. It restarts whenever an enable or a changed setting is applied, and it clears at once when the synthesizer is disabled. A read-only status word reports the active settings and the lock flag, not the pending ones. The intended bring-up is to apply enable alone, poll lock, and then apply enable together with connect. The synthesizer output is selected only when the PLL is enabled, connected and locked. Otherwise the clock tree stays on the reference chosen by a separate 2-bit source register, which is written directly and is not feed protected.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset all pending and active fields, the source select, the unlock state and the lock flag are zero, so every output and every register read returns zero.
- R2: Word addresses are 0 control, 1 configuration, 2 feed, 3 status and 4 source select; any other address reads zero. A write to control or configuration changes only the pending value, which reads back at once, while the active outputs keep their old values.
- R3: Writing 32'hAA to the feed address and then, as the next bus write, 32'h55 copies both pending words to the active outputs on the clock edge of the second write.
- R4: A feed write of any other value, or a write to any other address between 32'hAA and 32'h55, cancels the unlock, and a later 32'h55 applies nothing. Reads do not cancel it, and a repeated 32'hAA re-arms it.
- R5: The status word carries the active multiplier field in bits 14:0, the active pre-divider field in bits 23:16, the active enable in bit 24, the active connect in bit 25 and lock in bit 26; all other bits read zero.
- R6: When an apply sets enable while it was clear, or sets it with a changed multiplier or pre-divider, lock clears on that edge and rises exactly LOCK_CYCLES clock edges later. An apply that clears enable clears lock on the same edge. An apply that changes neither keeps the count running.
- R7: `out_sel_pll` is high only when the active enable, active connect and lock are all high.
- R8: The source select register keeps bits 1:0 of a write at once and reads them back raw. `clk_src` is 00 internal RC, 01 main oscillator, 10 RTC oscillator, and the reserved code 11 drives 00.
- R9: Reads of the feed address return zero, and writes to the status address leave every output and register unchanged.
- R10: Configuration writes keep only the multiplier field in bits 14:0 and the pre-divider field in bits 23:16. Control writes keep only bit 0 (enable) and bit 1 (connect). Dropped bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe, zero otherwise |
| pll_mul | output | 15 | Active multiplier minus one |
| pll_prediv | output | 8 | Active pre-divider minus one |
| pll_enable | output | 1 | Active enable |
| pll_connect | output | 1 | Active connect request |
| pll_locked | output | 1 | Modelled lock flag |
| out_sel_pll | output | 1 | Clock tree takes the synthesizer output |
| clk_src | output | 2 | Effective reference source |

## Verification
The unlock is driven with the clean pair, with a wrong second value, with a foreign write and with an unmapped write placed between the keys, with a read between the keys, and with a doubled first key. These cases separate "consecutive writes" from "consecutive cycles" and show that a stray write really cancels the unlock. Lock timing is checked for a first enable, a connect-only apply (no restart), a changed configuration (restart) and a disable (immediate clear). Each pattern is compared cycle by cycle against a behavioural model, so an off-by-one in the lock count shows up as a difference on one exact cycle. All four source codes are written, and every address is read back, including the status word while lock is pending.

// File: rtl/pll_feed_regs.sv
module pll_feed_regs #(
  parameter int          ADDR_W      = 3,
  parameter int          MUL_W       = 15,
  parameter int          DIV_W       = 8,
  parameter int          LOCK_CYCLES = 16,
  parameter logic [31:0] FEED_KEY0   = 32'h0000_00AA,
  parameter logic [31:0] FEED_KEY1   = 32'h0000_0055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic [MUL_W-1:0]  pll_mul,
  output logic [DIV_W-1:0]  pll_prediv,
  output logic              pll_enable,
  output logic              pll_connect,
  output logic              pll_locked,
  output logic              out_sel_pll,
  output logic [1:0]        clk_src
);
  localparam int DIV_LSB = 16;
  localparam int EN_BIT  = 24;
  localparam int CON_BIT = 25;
  localparam int LK_BIT  = 26;
  localparam int CNT_W   = $clog2(LOCK_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(4);

  logic [MUL_W-1:0] mul_p;
  logic [DIV_W-1:0] div_p;
  logic             en_p, con_p;
  logic             armed;
  logic [1:0]       src_q;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      cfg_word, ctl_word, stat_word;

  wire wr_feed = bus_we && bus_addr == A_FEED;
  wire apply   = wr_feed && armed && bus_wdata == FEED_KEY1;
  wire restart = apply && en_p &&
                 (!pll_enable || mul_p != pll_mul || div_p != pll_prediv);
  wire drop    = apply && !en_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul_p <= '0;
      div_p <= '0;
      en_p  <= 1'b0;
      con_p <= 1'b0;
      src_q <= 2'b00;
    end else if (bus_we) begin
      if (bus_addr == A_CFG) begin
        mul_p <= bus_wdata[MUL_W-1:0];
        div_p <= bus_wdata[DIV_LSB +: DIV_W];
      end
      if (bus_addr == A_CTRL) begin
        en_p  <= bus_wdata[0];
        con_p <= bus_wdata[1];
      end
      if (bus_addr == A_SRC) src_q <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (bus_we) armed <= wr_feed && bus_wdata == FEED_KEY0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_mul     <= '0;
      pll_prediv  <= '0;
      pll_enable  <= 1'b0;
      pll_connect <= 1'b0;
    end else if (apply) begin
      pll_mul     <= mul_p;
      pll_prediv  <= div_p;
      pll_enable  <= en_p;
      pll_connect <= con_p;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || drop || !pll_enable) begin
      cnt        <= '0;
      pll_locked <= 1'b0;
    end else if (!pll_locked) begin
      if (cnt == CNT_W'(LOCK_CYCLES - 1)) pll_locked <= 1'b1;
      else                                cnt        <= cnt + 1'b1;
    end
  end

  assign out_sel_pll = pll_enable && pll_connect && pll_locked;
  assign clk_src     = (src_q == 2'b11) ? 2'b00 : src_q;

  always_comb begin
    cfg_word = '0;
    cfg_word[MUL_W-1:0]        = mul_p;
    cfg_word[DIV_LSB +: DIV_W] = div_p;
    ctl_word = {30'd0, con_p, en_p};
    stat_word = '0;
    stat_word[MUL_W-1:0]        = pll_mul;
    stat_word[DIV_LSB +: DIV_W] = pll_prediv;
    stat_word[EN_BIT]           = pll_enable;
    stat_word[CON_BIT]          = pll_connect;
    stat_word[LK_BIT]           = pll_locked;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctl_word;
        A_CFG:   bus_rdata = cfg_word;
        A_STAT:  bus_rdata = stat_word;
        A_SRC:   bus_rdata = {30'd0, src_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pll_feed_regs_chk.sv
module pll_feed_regs_chk #(
  parameter int ADDR_W = 3,
  parameter int MUL_W  = 15,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic [MUL_W-1:0]  pll_mul,
  input logic [DIV_W-1:0]  pll_prediv,
  input logic              pll_enable,
  input logic              pll_connect,
  input logic              pll_locked,
  input logic              out_sel_pll,
  input logic [1:0]        clk_src
);
  wire key1_wr = bus_we && bus_addr == ADDR_W'(2) && bus_wdata == 32'h55;

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key1_wr |=> $stable({pll_mul, pll_prediv, pll_enable, pll_connect}));

  // R7
  out_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel_pll |-> (pll_enable && pll_connect && pll_locked));

  // R6
  lock_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked |-> pll_enable);

  // R6
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_enable) |-> !pll_locked);

  // R8
  src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_src != 2'b11);

  // R9
  feed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(2)) |-> bus_rdata == 32'd0);
endmodule

bind pll_feed_regs pll_feed_regs_chk #(.ADDR_W(ADDR_W), .MUL_W(MUL_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pll_mul(pll_mul),
  .pll_prediv(pll_prediv), .pll_enable(pll_enable), .pll_connect(pll_connect),
  .pll_locked(pll_locked), .out_sel_pll(out_sel_pll), .clk_src(clk_src)
);

// File: tb/tb_pll_feed_regs.sv
module tb_pll_feed_regs;
  localparam int L = 16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [14:0] pll_mul;
  logic [7:0]  pll_prediv;
  logic        pll_enable, pll_connect, pll_locked, out_sel_pll;
  logic [1:0]  clk_src;

  int n_chk = 0, n_bad = 0, cycles = 0;

  pll_feed_regs #(.LOCK_CYCLES(L)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pll_mul(pll_mul),
    .pll_prediv(pll_prediv), .pll_enable(pll_enable), .pll_connect(pll_connect),
    .pll_locked(pll_locked), .out_sel_pll(out_sel_pll), .clk_src(clk_src));

  always #2 clk = ~clk;

  // behavioural reference
  int m_pmul, m_pdiv, m_pctl, m_src, m_amul, m_adiv, m_en, m_con, m_lk, m_remain;
  bit m_armed;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pmul = 0; m_pdiv = 0; m_pctl = 0; m_src = 0; m_amul = 0; m_adiv = 0;
      m_en = 0; m_con = 0; m_lk = 0; m_remain = 0; m_armed = 0;
    end else begin
      bit go, clr;
      logic [31:0] d;
      int a;
      d = bus_wdata; a = bus_addr; go = 0; clr = 0;
      if (bus_we) begin
        go = (a == 2) && (d == 32'h55) && m_armed;
        m_armed = (a == 2) && (d == 32'hAA);
        if (go) begin
          clr = ((m_pctl & 1) == 0) ||
                (m_en == 0 || m_pmul != m_amul || m_pdiv != m_adiv);
          m_amul = m_pmul; m_adiv = m_pdiv;
          m_en = m_pctl & 1; m_con = (m_pctl >> 1) & 1;
        end
        if (a == 0) m_pctl = int'(d & 32'h3);
        if (a == 1) begin m_pmul = int'(d & 32'h7FFF); m_pdiv = int'((d >> 16) & 32'hFF); end
        if (a == 4) m_src = int'(d & 32'h3);
      end
      if (clr) begin
        m_lk = 0; m_remain = m_en ? L : 0;
      end else if (m_en == 0) m_lk = 0;
      else if (m_lk == 0) begin
        m_remain--;
        if (m_remain == 0) m_lk = 1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    logic [31:0] s;
    if (!bus_re) return 0;
    case (bus_addr)
      0: return 32'(m_pctl);
      1: return 32'(m_pmul | (m_pdiv << 16));
      3: begin
        s = 32'(m_amul | (m_adiv << 16) | (m_en << 24) | (m_con << 25) | (m_lk << 26));
        return s;
      end
      4: return 32'(m_src);
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) if (rst_n) begin
    check("R3 multiplier", 32'(pll_mul), 32'(m_amul));
    check("R3 prediv", 32'(pll_prediv), 32'(m_adiv));
    check("R3 enable", 32'(pll_enable), 32'(m_en));
    check("R3 connect", 32'(pll_connect), 32'(m_con));
    check("R6 lock", 32'(pll_locked), 32'(m_lk));
    check("R7 out_sel", 32'(out_sel_pll), 32'(m_en & m_con & m_lk));
    check("R8 clk_src", 32'(clk_src), 32'(m_src == 3 ? 0 : m_src));
    case (bus_addr)
      2:       check("R9 feed read", bus_rdata, exp_rd());
      3:       check("R5 status read", bus_rdata, exp_rd());
      4:       check("R8 source read", bus_rdata, exp_rd());
      default: check("R2 R10 register read", bus_rdata, exp_rd());
    endcase
  end

  task automatic wr(int a, logic [31:0] d);
    bus_addr = 3'(a); bus_wdata = d; bus_we = 1; bus_re = 0;
    @(posedge clk); #1; bus_we = 0;
  endtask
  task automatic rd(int a);
    bus_addr = 3'(a); bus_re = 1; bus_we = 0;
    @(posedge clk); #1; bus_re = 0;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic feed();
    wr(2, 32'hAA); wr(2, 32'h55);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 outputs", {pll_mul, pll_prediv, pll_enable, pll_connect, pll_locked, out_sel_pll, clk_src}, 0);
    rd(3); rd(0); rd(1); rd(4);
    // R10 field masking
    wr(0, 32'hFFFF_FFFF); rd(0);
    wr(1, 32'hFFFF_FFFF); rd(1);
    wr(1, 32'h0002_0031); wr(0, 32'h1);
    // R2 still inactive before feed
    check("R2 pending only", 32'(pll_enable), 0);
    feed();
    for (int i = 0; i < L + 3; i++) rd(3);
    // R4 foreign write between keys
    wr(0, 32'h3);
    wr(2, 32'hAA); wr(1, 32'h0002_0031); wr(2, 32'h55);
    check("R4 foreign write aborts", 32'(pll_connect), 0);
    wr(2, 32'hAA); wr(2, 32'h12); wr(2, 32'h55);
    check("R4 wrong key aborts", 32'(pll_connect), 0);
    wr(2, 32'hAA); wr(6, 32'h0); wr(2, 32'h55);
    check("R4 unmapped write aborts", 32'(pll_connect), 0);
    // R4 read between keys does not abort, doubled first key re-arms
    wr(2, 32'hAA); wr(2, 32'hAA); rd(2); rd(3); wr(2, 32'h55);
    check("R4 read keeps unlock", 32'(pll_connect), 1);
    idle(3);
    // R6 config change restarts lock
    wr(1, 32'h0001_0010); feed();
    for (int i = 0; i < L + 2; i++) rd(3);
    // R6 connect-only apply keeps count: drop connect then reconnect mid count
    wr(1, 32'h0003_0020); wr(0, 32'h1); feed();
    idle(5); wr(0, 32'h3); feed();
    for (int i = 0; i < L; i++) rd(3);
    // R9 status write ignored
    wr(3, 32'hFFFF_FFFF); rd(3); rd(2);
    // R6 disable clears lock at once
    wr(0, 32'h0); feed(); rd(3); idle(3);
    // R8 all source codes
    for (int c = 0; c < 4; c++) begin wr(4, 32'(c)); rd(4); end
    wr(4, 32'hFFFF_FFFE); rd(4);
    rd(5); rd(7);
    // re-enable after disable, same config
    wr(0, 32'h3); feed();
    for (int i = 0; i < L + 2; i++) rd(3);
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule